// File: doc/BRIEF.md
# Clock prescaler, interval timer and watchdog chain

This block is the timing backbone of a small microcontroller. A free-running 10-bit binary prescaler divides the system clock, and all ten of its stage outputs are offered to other peripherals as divided clocks. An 8-bit interval counter advances at a rate picked from the prescaler. Each time it wraps it raises a periodic interrupt pulse, and the first wrap after reset marks the end of the oscillator settling wait.

The interval-counter wrap is the only clock of a 6-bit watchdog counter. At each wrap the watchdog count is compared with a programmable limit. On a match the count restarts from zero and, depending on a mode bit, either a device reset pulse or a watchdog interrupt pulse is issued. Software reaches the block through a four-location register port: a clock control register, a watchdog setup register and read access to both counters. Writing a clear bit restarts both counters together.

Top module: `tick_chain`

## Requirements
- R1: `tap_o` is a 10-bit counter that is 0 at reset and increments by one on every clock edge, wrapping from 1023 to 0.
- R2: With clock control bits [2:0] = s and run bit [4] = 1, the interval counter increments exactly on the clock edges that take `tap_o` to a multiple of 2^(s+3) (s = 0 is divide-by-8, s = 7 is divide-by-1024). With bit [4] = 0 it holds its value.
- R3: The interval counter is 8 bits wide and wraps from 255 to 0. `bit_irq_o` is high for exactly the one cycle that follows the wrapping edge.
- R4: `osc_ready_o` is 0 from reset until the first interval-counter wrap, goes to 1 in the same cycle as that wrap's `bit_irq_o`, and then stays 1.
- R5: With watchdog enable bit [5] of the clock control register at 1, the watchdog counter advances by one at each interval wrap. With that bit at 0 it holds.
- R6: At an enabled interval wrap where the watchdog count equals the compare field (watchdog register bits [5:0]), the count returns to 0. In the cycle of that wrap's `bit_irq_o`, `wdt_rst_o` pulses if the mode bit (watchdog register bit [6]) is 1, and `wdt_irq_o` pulses if it is 0. The two are never high together.
- R7: Writing the clock control register with bit [3] = 1 zeroes both counters at that edge, and this overrides a step due at the same edge. The prescaler is not affected, and bit [3] always reads back 0.
- R8: After reset the clock control register reads 0x17 (select 7, run 1, watchdog enable 0), the watchdog register reads 0x3F (mode 0, compare 63), both counters read 0, and all pulse outputs are low.
- R9: Address 0 is clock control, 1 is watchdog setup {0, mode, compare}, 2 is the interval count and 3 is the watchdog count {00, count}. `rd_data_o` follows `addr_i` combinationally with no side effect, and writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` |
| tap_o | output | 10 | Prescaler stage outputs |
| bit_irq_o | output | 1 | Interval wrap interrupt pulse |
| wdt_irq_o | output | 1 | Watchdog match interrupt pulse (mode 0) |
| wdt_rst_o | output | 1 | Watchdog match reset pulse (mode 1) |
| osc_ready_o | output | 1 | Oscillator settling wait finished |

## Verification
Several properties are checked on every cycle: the prescaler step, the interval counter reading zero when a wrap pulse appears, the ready flag never falling, watchdog pulses only riding on a wrap pulse and never together, a reset pulse only under mode 1, and the clear write leaving both counters at zero. The exact wrap cycles for each tap selection, the compare period in overflows, the choice between reset and interrupt, the hold of a disabled watchdog and the ignored writes to the counter addresses can only be shown by the bench scenarios. These scenarios predict each pulse's cycle from the prescaler phase at the clearing write.

// File: rtl/tick_chain_pkg.sv
package tick_chain_pkg;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 3;
  localparam int CLR_BIT  = 3;
  localparam int RUN_BIT  = 4;
  localparam int WEN_BIT  = 5;
  localparam int MODE_BIT = 6;

  typedef enum logic [1:0] {
    ADDR_CTL  = 2'd0,
    ADDR_WDT  = 2'd1,
    ADDR_ICNT = 2'd2,
    ADDR_WCNT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
  parameter int PRE_W    = 10,
  parameter int SEL_W    = 3,
  parameter int SEL_BASE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [PRE_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + PRE_W'(1);
  end

  // low stages up to the selected tap all ones: last cycle of a tap period
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (i <= int'(sel_i) + SEL_BASE);
  end

  assign tick_o = &(cnt_q | ~mask);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tc_interval.sv
module tc_interval #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step  = tick_i && run_i && !clr_i;
  assign ovf_o = step && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tc_watchdog.sv
module tc_watchdog #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             rst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             adv, match;
  logic             irq_q, rst_q;

  assign adv   = step_i && en_i && !clr_i;
  assign match = adv && (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= match && !mode_i;
      rst_q <= match && mode_i;
      if (clr_i || match) cnt_q <= '0;
      else if (adv)       cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
  assign rst_o = rst_q;
endmodule

// File: rtl/tick_chain.sv
module tick_chain
  import tick_chain_pkg::*;
#(
  parameter int PRE_W    = 10,
  parameter int ICNT_W   = 8,
  parameter int WCNT_W   = 6,
  parameter int SEL_BASE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PRE_W-1:0]  tap_o,
  output logic              bit_irq_o,
  output logic              wdt_irq_o,
  output logic              wdt_rst_o,
  output logic              osc_ready_o
);
  logic [SEL_W-1:0]  sel_q;
  logic              run_q, wen_q, mode_q;
  logic [WCNT_W-1:0] cmp_q;
  logic              wr_ctl, wr_wdt, clr;
  logic              tick, ovf;
  logic [ICNT_W-1:0] icnt;
  logic [WCNT_W-1:0] wcnt;
  logic              bit_irq_q, ready_q;

  assign wr_ctl = wr_en_i && (addr_i == ADDR_CTL);
  assign wr_wdt = wr_en_i && (addr_i == ADDR_WDT);
  assign clr    = wr_ctl && wr_data_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '1;
      run_q  <= 1'b1;
      wen_q  <= 1'b0;
      cmp_q  <= '1;
      mode_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        sel_q <= wr_data_i[SEL_W-1:0];
        run_q <= wr_data_i[RUN_BIT];
        wen_q <= wr_data_i[WEN_BIT];
      end
      if (wr_wdt) begin
        cmp_q  <= wr_data_i[WCNT_W-1:0];
        mode_q <= wr_data_i[MODE_BIT];
      end
    end
  end

  tc_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W), .SEL_BASE(SEL_BASE)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel_q),
    .cnt_o (tap_o),
    .tick_o(tick)
  );

  tc_interval #(.CNT_W(ICNT_W)) u_ivl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .run_i (run_q),
    .tick_i(tick),
    .cnt_o (icnt),
    .ovf_o (ovf)
  );

  tc_watchdog #(.CNT_W(WCNT_W)) u_wdt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .en_i  (wen_q),
    .step_i(ovf),
    .mode_i(mode_q),
    .cmp_i (cmp_q),
    .cnt_o (wcnt),
    .irq_o (wdt_irq_o),
    .rst_o (wdt_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_irq_q <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      bit_irq_q <= ovf;
      ready_q   <= ready_q || ovf;
    end
  end

  assign bit_irq_o   = bit_irq_q;
  assign osc_ready_o = ready_q;

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      ADDR_CTL: begin
        rd_data_o[SEL_W-1:0] = sel_q;
        rd_data_o[RUN_BIT]   = run_q;
        rd_data_o[WEN_BIT]   = wen_q;
      end
      ADDR_WDT: begin
        rd_data_o[WCNT_W-1:0] = cmp_q;
        rd_data_o[MODE_BIT]   = mode_q;
      end
      ADDR_ICNT: rd_data_o[ICNT_W-1:0] = icnt;
      default:   rd_data_o[WCNT_W-1:0] = wcnt;
    endcase
  end
endmodule

// File: rtl/tick_chain_chk.sv
module tick_chain_chk #(
  parameter int PRE_W  = 10,
  parameter int ICNT_W = 8,
  parameter int WCNT_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [7:0]        wr_data_i,
  input logic [PRE_W-1:0]  tap_o,
  input logic              bit_irq_o,
  input logic              wdt_irq_o,
  input logic              wdt_rst_o,
  input logic              osc_ready_o,
  input logic [ICNT_W-1:0] icnt,
  input logic [WCNT_W-1:0] wcnt,
  input logic              mode_q
);
  a_r1_prescaler_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> tap_o == PRE_W'($past(tap_o) + PRE_W'(1)));

  a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_irq_o |-> icnt == '0);

  a_r4_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(osc_ready_o) |-> osc_ready_o);

  a_r4_ready_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_irq_o |-> osc_ready_o);

  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdt_irq_o && wdt_rst_o));

  a_r6_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_irq_o || wdt_rst_o) |-> bit_irq_o);

  a_r6_reset_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(mode_q));

  a_r7_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && addr_i == 2'd0 && wr_data_i[3]) |-> (icnt == '0 && wcnt == '0));
endmodule

bind tick_chain tick_chain_chk #(.PRE_W(PRE_W), .ICNT_W(ICNT_W), .WCNT_W(WCNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wr_data_i  (wr_data_i),
  .tap_o      (tap_o),
  .bit_irq_o  (bit_irq_o),
  .wdt_irq_o  (wdt_irq_o),
  .wdt_rst_o  (wdt_rst_o),
  .osc_ready_o(osc_ready_o),
  .icnt       (icnt),
  .wcnt       (wcnt),
  .mode_q     (mode_q)
);

// File: tb/tick_chain_test.sv
`timescale 1ns/1ps
module tick_chain_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [9:0] tap;
  logic       bit_irq, wdt_irq, wdt_rst, ready;

  int    checks = 0;
  int    fails  = 0;
  longint cyc   = 0;

  typedef struct { int kind; longint at; } evt_t;
  evt_t exp_q[$];

  always #4 clk = ~clk;

  tick_chain uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .tap_o(tap),
    .bit_irq_o(bit_irq), .wdt_irq_o(wdt_irq), .wdt_rst_o(wdt_rst),
    .osc_ready_o(ready)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: pops expected pulses as the design produces them
  task automatic take(input int kind);
    string req;
    evt_t e;
    req = (kind == 0) ? "R3" : "R6";
    if (exp_q.size() == 0) begin
      check(1'b0, {req, " unexpected pulse"}, cyc, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, {req, " pulse kind"}, kind, e.kind);
      check(e.at == cyc, {req, " pulse cycle"}, cyc, e.at);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bit_irq) take(0);
    if (wdt_irq) take(1);
    if (wdt_rst) take(2);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output longint w);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    w = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_to(input longint target);
    while (cyc < target) @(negedge clk);
  endtask

  // driver: expected pulses after a clearing write at edge w
  task automatic push_run(input longint w, input int s, input int n, input int cmp,
                          input bit mode, input bit wen, output longint first_at, output longint last_at);
    longint p, m1, e;
    int wc;
    p  = longint'(1) << (s + 3);
    m1 = (w / p + 1) * p;
    wc = 0;
    first_at = 0;
    last_at  = 0;
    for (int k = 1; k <= n; k++) begin
      e = m1 + (256 * k - 1) * p;
      exp_q.push_back('{0, e});
      if (wen) begin
        if (wc == cmp) begin
          exp_q.push_back('{mode ? 2 : 1, e});
          wc = 0;
        end else wc++;
      end
      if (k == 1) first_at = e;
      last_at = e;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog timeout", cyc, 0);
    finish_up();
  end

  initial begin
    logic [7:0] d;
    longint w, f, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset state
    check(!bit_irq && !wdt_irq && !wdt_rst && !ready, "R8 outputs low", {bit_irq, wdt_irq, wdt_rst, ready}, 0);
    rd(2'd0, d); check(d == 8'h17, "R8 ctl reset", d, 8'h17);
    rd(2'd1, d); check(d == 8'h3F, "R8 wdt reset", d, 8'h3F);
    rd(2'd2, d); check(d == 8'h00, "R8 interval count", d, 0);
    rd(2'd3, d); check(d == 8'h00, "R8 watchdog count", d, 0);
    @(negedge clk); check(tap == 10'(cyc % 1024), "R1 prescaler", tap, cyc % 1024);

    // R5/R6 interrupt mode, compare 1, tap divide-by-8
    wr(2'd1, 8'h01, w);
    wr(2'd0, 8'h38, w);
    rd(2'd0, d); check(d == 8'h30, "R7 clear bit reads 0", d, 8'h30);
    check(!ready, "R4 not ready before wrap", ready, 0);
    push_run(w, 0, 4, 1, 1'b0, 1'b1, f, l);
    wait_to(w + 700);
    rd(2'd2, d); check(d == 8'((cyc / 8) - (w / 8)), "R2 divide-by-8 count", d, 8'((cyc / 8) - (w / 8)));
    wait_to(f + 2);
    check(ready, "R4 ready after first wrap", ready, 1);
    rd(2'd3, d); check(d == 8'd1, "R5 watchdog advanced", d, 1);
    wait_to(l + 2);
    rd(2'd3, d); check(d == 8'd0, "R6 restart after match", d, 0);
    check(tap == 10'(cyc % 1024), "R1 prescaler after wrap", tap, cyc % 1024);

    // R6 reset mode, compare 0, divide-by-16
    wr(2'd1, 8'h40, w);
    wr(2'd0, 8'h39, w);
    push_run(w, 1, 2, 0, 1'b1, 1'b1, f, l);
    wait_to(l + 3);

    // R5 watchdog disabled: wrap only
    wr(2'd0, 8'h18, w);
    push_run(w, 0, 1, 0, 1'b1, 1'b0, f, l);
    wait_to(l + 3);
    rd(2'd3, d); check(d == 8'd0, "R5 disabled watchdog holds", d, 0);

    // R2 divide-by-64 count, R7 clear mid-run
    wr(2'd0, 8'h1B, w);
    wait_to(w + 1000);
    rd(2'd2, d); check(d == 8'((cyc / 64) - (w / 64)), "R2 divide-by-64 count", d, 8'((cyc / 64) - (w / 64)));
    wr(2'd0, 8'h1B, w);
    rd(2'd2, d); check(d == 8'd0, "R7 clear zeroes count", d, 0);
    check(tap == 10'(cyc % 1024), "R7 prescaler unaffected", tap, cyc % 1024);

    // R2 run off holds, R9 counter writes ignored
    wr(2'd0, 8'h08, w);
    wait_to(w + 300);
    rd(2'd2, d); check(d == 8'd0, "R2 stopped counter holds", d, 0);
    wr(2'd2, 8'h55, w);
    wr(2'd3, 8'h2A, w);
    rd(2'd2, d); check(d == 8'd0, "R9 interval write ignored", d, 0);
    rd(2'd3, d); check(d == 8'd0, "R9 watchdog write ignored", d, 0);
    rd(2'd1, d); check(d == 8'h40, "R9 watchdog setup readback", d, 8'h40);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected pulses seen", exp_q.size(), 0);
    finish_up();
  end
endmodule